// File: doc/BRIEF.md
# Cross-Page Codeword Interleaver

This block sits between an ECC codec and the flash page interface. Each codeword is split in half. The first half goes into the lower page of a wordline and the second half into the upper page of the same wordline, at the same byte offset in both. Every codeword therefore sees the mean of the two pages' raw error rates, and one code rate serves all codewords. Programming and sensing work on whole pages, so both directions keep a two-page staging buffer.

On the write side, codewords arrive as a valid/ready byte stream. After the last codeword that fits has been accepted, the block stops taking input. It then emits the lower page image, then the upper page image, each as a full page of bytes with a page-select flag and a last-byte strobe. Each page has `PAGE_BYTES/(CW_BYTES/2)` half-codeword slots. A codeword that would not fit completely is held back for the next wordline pair, and each page tail is filled with 0xFF. On the read side the block takes the lower page image and then the upper page image. It rebuilds the codewords in their written order and discards the tail bytes. The codeword length `CW_BYTES` is a single parameter, so there is one code rate at a time.

Top module: `xpage_cw_interleaver`

## Requirements
- R1: After reset, `wr_in_ready`=1, `pg_out_valid`=0, `pg_in_ready`=1, `rd_page_upper`=0 and `cw_out_valid`=0.
- R2: With H=`CW_BYTES`/2, byte j<H of the c-th codeword in a wordline pair is emitted at lower-page offset c*H+j. Byte H+j of the same codeword is emitted at upper-page offset c*H+j.
- R3: Exactly C=floor(`PAGE_BYTES`/H) codewords are accepted per wordline pair. After the C-th codeword, `wr_in_ready` stays 0 until the upper page has been fully emitted, and then returns to 1.
- R4: Page offsets at or beyond C*H are emitted as 0xFF on the write side, and their values are ignored on the read side.
- R5: The lower page is emitted first with `pg_out_upper`=0, then the upper page with `pg_out_upper`=1. Each page is exactly `PAGE_BYTES` byte transfers, starting at offset 0.
- R6: `pg_out_done` is 1 only during the handshake of the last byte of each page.
- R7: The read side accepts `PAGE_BYTES` bytes with `rd_page_upper`=0 (lower page) and then `PAGE_BYTES` bytes with `rd_page_upper`=1. It then holds `pg_in_ready` at 0 while codewords are being emitted.
- R8: The read side emits exactly C*`CW_BYTES` bytes per pair, reproducing the codewords in their written order. It then drops `cw_out_valid` and raises `pg_in_ready`.
- R9: While a valid output is stalled by its ready input, its data and page flag stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_in_valid | input | 1 | Encoder byte valid |
| wr_in_ready | output | 1 | Block accepts an encoder byte |
| wr_in_data | input | 8 | Encoder codeword byte |
| pg_out_valid | output | 1 | Page byte valid toward flash |
| pg_out_ready | input | 1 | Flash side accepts page byte |
| pg_out_data | output | 8 | Page image byte |
| pg_out_upper | output | 1 | 0: lower page, 1: upper page |
| pg_out_done | output | 1 | Last byte of a page is transferring |
| pg_in_valid | input | 1 | Page byte valid from flash |
| pg_in_ready | output | 1 | Block accepts a page byte |
| pg_in_data | input | 8 | Sensed page byte |
| rd_page_upper | output | 1 | Page expected next: 0 lower, 1 upper |
| cw_out_valid | output | 1 | Rebuilt codeword byte valid |
| cw_out_ready | input | 1 | Decoder accepts byte |
| cw_out_data | output | 8 | Rebuilt codeword byte |

## Verification
Several properties are checked on every cycle: output stability under backpressure, the last-byte strobe landing on the final handshake of a page, 0xFF in every tail offset, the input capacity limit per pair, and the exclusion between loading pages and emitting codewords. Other behaviour can only be shown by the bench's scenarios, because it needs a byte-by-byte comparison against computed offsets. That covers where each codeword half lands in the page images, the lower-then-upper ordering, and the faithful rebuild of the codeword order on read-back, including non-0xFF junk in the tail being dropped.

// File: rtl/xpage_pkg.sv
// Shared types for the cross-page codeword interleaver.
// Assumes byte-wide streams on every side.
package xpage_pkg;
    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        WS_FILL  = 2'd0,
        WS_LOWER = 2'd1,
        WS_UPPER = 2'd2
    } wr_state_t;

    typedef enum logic [1:0] {
        RS_LOWER = 2'd0,
        RS_UPPER = 2'd1,
        RS_EMIT  = 2'd2
    } rd_state_t;

    // Number of half-codeword slots that fit in one page.
    function automatic int slots_per_page(input int page_bytes, input int half_bytes);
        return page_bytes / half_bytes;
    endfunction
endpackage

// File: rtl/xpage_page_buf.sv
// Two-page byte store (lower and upper page of one wordline).
// One synchronous write port, one combinational read port.
// Assumes contents need no reset; tail padding is applied by the caller.
module xpage_page_buf #(
    parameter int PAGE_BYTES = 64,
    localparam int AW = $clog2(PAGE_BYTES)
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic                 wsel,
    input  logic [AW-1:0]        waddr,
    input  xpage_pkg::byte_t     wdata,
    input  logic                 rsel,
    input  logic [AW-1:0]        raddr,
    output xpage_pkg::byte_t     rdata
);
    xpage_pkg::byte_t mem [2][PAGE_BYTES];

    // Store one byte into the selected page.
    always_ff @(posedge clk) begin
        if (we) mem[wsel][waddr] <= wdata;
    end

    // Read one byte from the selected page.
    always_comb rdata = mem[rsel][raddr];
endmodule

// File: rtl/xpage_cw_walk.sv
// Walks codeword bytes onto (page, offset) pairs. Bytes 0..H-1 of codeword c
// map to the lower page at c*H+j, and bytes H..2H-1 to the upper page at the
// same offsets. last flags the final byte of the final codeword in a pair.
// Assumes step is only raised when a byte actually moves.
module xpage_cw_walk #(
    parameter int PAGE_BYTES = 64,
    parameter int HALF_BYTES = 6,
    parameter int SLOTS      = 10,
    localparam int AW = $clog2(PAGE_BYTES),
    localparam int BW = $clog2(HALF_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [AW-1:0] off,
    output logic          upper,
    output logic          last
);
    localparam logic [BW-1:0] B_LAST    = BW'(HALF_BYTES - 1);
    localparam logic [AW-1:0] BASE_LAST = AW'((SLOTS - 1) * HALF_BYTES);
    localparam logic [AW-1:0] BASE_INC  = AW'(HALF_BYTES);

    logic [BW-1:0] bidx;
    logic [AW-1:0] base;

    // Current offset and last-byte flag.
    always_comb begin
        off  = base + AW'(bidx);
        last = upper && (bidx == B_LAST) && (base == BASE_LAST);
    end

    // Advance byte index, half select and slot base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bidx  <= '0;
            base  <= '0;
            upper <= 1'b0;
        end else if (step) begin
            if (bidx == B_LAST) begin
                bidx <= '0;
                if (!upper) begin
                    upper <= 1'b1;
                end else begin
                    upper <= 1'b0;
                    base  <= last ? '0 : base + BASE_INC;
                end
            end else begin
                bidx <= bidx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/xpage_cw_interleaver.sv
// Cross-page codeword interleaver. The write path packs whole codewords
// half-and-half into a lower/upper page pair and then emits the two pages.
// The read path loads both pages and rebuilds the codewords in order.
// Assumes CW_BYTES is even and no larger than 2*PAGE_BYTES.
module xpage_cw_interleaver #(
    parameter int PAGE_BYTES = 64,
    parameter int CW_BYTES   = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_in_valid,
    output logic       wr_in_ready,
    input  logic [7:0] wr_in_data,
    output logic       pg_out_valid,
    input  logic       pg_out_ready,
    output logic [7:0] pg_out_data,
    output logic       pg_out_upper,
    output logic       pg_out_done,
    input  logic       pg_in_valid,
    output logic       pg_in_ready,
    input  logic [7:0] pg_in_data,
    output logic       rd_page_upper,
    output logic       cw_out_valid,
    input  logic       cw_out_ready,
    output logic [7:0] cw_out_data
);
    import xpage_pkg::*;

    localparam int HALF  = CW_BYTES / 2;
    localparam int SLOTS = slots_per_page(PAGE_BYTES, HALF);
    localparam int USED  = SLOTS * HALF;
    localparam int AW    = $clog2(PAGE_BYTES);
    localparam logic [AW-1:0] CNT_LAST = AW'(PAGE_BYTES - 1);

    // ---------------- write path ----------------
    wr_state_t     wst;
    logic [AW-1:0] wcnt;
    logic [AW-1:0] wwalk_off;
    logic          wwalk_upper, wwalk_last, wr_take, pg_take;
    byte_t         wbuf_q;

    // Write-side handshakes and page output.
    always_comb begin
        wr_in_ready  = (wst == WS_FILL);
        wr_take      = wr_in_valid && wr_in_ready;
        pg_out_valid = (wst != WS_FILL);
        pg_out_upper = (wst == WS_UPPER);
        pg_out_data  = (int'(wcnt) < USED) ? wbuf_q : 8'hFF;
        pg_take      = pg_out_valid && pg_out_ready;
        pg_out_done  = pg_take && (wcnt == CNT_LAST);
    end

    xpage_cw_walk #(.PAGE_BYTES(PAGE_BYTES), .HALF_BYTES(HALF), .SLOTS(SLOTS)) wwalk_i (
        .clk(clk), .rst_n(rst_n), .step(wr_take),
        .off(wwalk_off), .upper(wwalk_upper), .last(wwalk_last)
    );

    xpage_page_buf #(.PAGE_BYTES(PAGE_BYTES)) wbuf_i (
        .clk(clk), .we(wr_take), .wsel(wwalk_upper), .waddr(wwalk_off),
        .wdata(wr_in_data), .rsel(pg_out_upper), .raddr(wcnt), .rdata(wbuf_q)
    );

    // Write FSM: fill a pair, then emit lower and upper page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wst  <= WS_FILL;
            wcnt <= '0;
        end else begin
            case (wst)
                WS_FILL: if (wr_take && wwalk_last) begin
                    wst  <= WS_LOWER;
                    wcnt <= '0;
                end
                WS_LOWER, WS_UPPER: if (pg_take) begin
                    if (pg_out_done) begin
                        wcnt <= '0;
                        wst  <= (wst == WS_LOWER) ? WS_UPPER : WS_FILL;
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                default: wst <= WS_FILL;
            endcase
        end
    end

    // ---------------- read path ----------------
    rd_state_t     rdst;
    logic [AW-1:0] rcnt;
    logic [AW-1:0] rwalk_off;
    logic          rwalk_upper, rwalk_last, ld_take, ld_keep, cw_take;
    byte_t         rbuf_q;

    // Read-side handshakes and codeword output.
    always_comb begin
        pg_in_ready   = (rdst != RS_EMIT);
        rd_page_upper = (rdst == RS_UPPER);
        ld_take       = pg_in_valid && pg_in_ready;
        ld_keep       = ld_take && (int'(rcnt) < USED);
        cw_out_valid  = (rdst == RS_EMIT);
        cw_out_data   = rbuf_q;
        cw_take       = cw_out_valid && cw_out_ready;
    end

    xpage_cw_walk #(.PAGE_BYTES(PAGE_BYTES), .HALF_BYTES(HALF), .SLOTS(SLOTS)) rwalk_i (
        .clk(clk), .rst_n(rst_n), .step(cw_take),
        .off(rwalk_off), .upper(rwalk_upper), .last(rwalk_last)
    );

    xpage_page_buf #(.PAGE_BYTES(PAGE_BYTES)) rbuf_i (
        .clk(clk), .we(ld_keep), .wsel(rd_page_upper), .waddr(rcnt),
        .wdata(pg_in_data), .rsel(rwalk_upper), .raddr(rwalk_off), .rdata(rbuf_q)
    );

    // Read FSM: load lower page, load upper page, emit codewords.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdst <= RS_LOWER;
            rcnt <= '0;
        end else begin
            case (rdst)
                RS_LOWER, RS_UPPER: if (ld_take) begin
                    if (rcnt == CNT_LAST) begin
                        rcnt <= '0;
                        rdst <= (rdst == RS_LOWER) ? RS_UPPER : RS_EMIT;
                    end else begin
                        rcnt <= rcnt + 1'b1;
                    end
                end
                RS_EMIT: if (cw_take && rwalk_last) rdst <= RS_LOWER;
                default: rdst <= RS_LOWER;
            endcase
        end
    end
endmodule

// File: rtl/xpage_cw_interleaver_chk.sv
// Port-level checker for the cross-page codeword interleaver.
// Keeps its own byte counters; observes the top-level ports only.
module xpage_cw_interleaver_chk #(
    parameter int PAGE_BYTES = 64,
    parameter int CW_BYTES   = 12
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_in_valid,
    input logic       wr_in_ready,
    input logic       pg_out_valid,
    input logic       pg_out_ready,
    input logic [7:0] pg_out_data,
    input logic       pg_out_upper,
    input logic       pg_out_done,
    input logic       pg_in_ready,
    input logic       cw_out_valid,
    input logic       cw_out_ready,
    input logic [7:0] cw_out_data
);
    localparam int HALF  = CW_BYTES / 2;
    localparam int SLOTS = PAGE_BYTES / HALF;
    localparam int USED  = SLOTS * HALF;
    localparam int TOTAL = SLOTS * CW_BYTES;

    int pg_off;
    int wr_seen;
    int cw_seen;

    // Independent counters of bytes moved on each interface.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pg_off  <= 0;
            wr_seen <= 0;
            cw_seen <= 0;
        end else begin
            if (pg_out_valid && pg_out_ready)
                pg_off <= (pg_off == PAGE_BYTES - 1) ? 0 : pg_off + 1;
            if (pg_out_done && pg_out_upper)
                wr_seen <= 0;
            else if (wr_in_valid && wr_in_ready)
                wr_seen <= wr_seen + 1;
            if (pg_in_ready && !cw_out_valid && cw_seen == TOTAL)
                cw_seen <= 0;
            else if (cw_out_valid && cw_out_ready)
                cw_seen <= cw_seen + 1;
        end
    end

    assert_pad_ff_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pg_out_valid && pg_off >= USED |-> pg_out_data == 8'hFF);

    assert_done_on_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pg_out_done |-> pg_out_valid && pg_out_ready && pg_off == PAGE_BYTES - 1);

    assert_done_present_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pg_out_valid && pg_out_ready && pg_off == PAGE_BYTES - 1 |-> pg_out_done);

    assert_capacity_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_in_valid && wr_in_ready |-> wr_seen < TOTAL);

    assert_no_fill_while_drain_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pg_out_valid |-> !wr_in_ready);

    assert_upper_after_lower_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pg_out_upper) |-> $past(pg_out_done));

    assert_no_load_while_emit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cw_out_valid |-> !pg_in_ready);

    assert_emit_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cw_out_valid |-> cw_seen < TOTAL);

    assert_pg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pg_out_valid && !pg_out_ready |=> pg_out_valid && $stable(pg_out_data) && $stable(pg_out_upper));

    assert_cw_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cw_out_valid && !cw_out_ready |=> cw_out_valid && $stable(cw_out_data));
endmodule

bind xpage_cw_interleaver xpage_cw_interleaver_chk #(
    .PAGE_BYTES(PAGE_BYTES), .CW_BYTES(CW_BYTES)
) chk_i (
    .clk(clk), .rst_n(rst_n),
    .wr_in_valid(wr_in_valid), .wr_in_ready(wr_in_ready),
    .pg_out_valid(pg_out_valid), .pg_out_ready(pg_out_ready),
    .pg_out_data(pg_out_data), .pg_out_upper(pg_out_upper),
    .pg_out_done(pg_out_done), .pg_in_ready(pg_in_ready),
    .cw_out_valid(cw_out_valid), .cw_out_ready(cw_out_ready),
    .cw_out_data(cw_out_data)
);

// File: tb/xpage_cw_interleaver_tb.sv
// Bench: three wordline pairs written, drained with and without backpressure,
// looped back into the read side with junk in the page tails, and compared.
module xpage_cw_interleaver_tb_top;
    localparam int PAGE  = 64;
    localparam int CW    = 12;
    localparam int HALF  = CW / 2;
    localparam int SLOTS = PAGE / HALF;
    localparam int USED  = SLOTS * HALF;
    localparam int TOTAL = SLOTS * CW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_in_valid = 1'b0, pg_out_ready = 1'b0, pg_in_valid = 1'b0, cw_out_ready = 1'b0;
    logic [7:0] wr_in_data = '0, pg_in_data = '0;
    logic wr_in_ready, pg_out_valid, pg_out_upper, pg_out_done;
    logic pg_in_ready, rd_page_upper, cw_out_valid;
    logic [7:0] pg_out_data, cw_out_data;

    int checks = 0;
    int errors = 0;
    logic [7:0] lo_pg [PAGE];
    logic [7:0] hi_pg [PAGE];

    always #5 clk = ~clk;

    xpage_cw_interleaver #(.PAGE_BYTES(PAGE), .CW_BYTES(CW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_in_valid(wr_in_valid), .wr_in_ready(wr_in_ready), .wr_in_data(wr_in_data),
        .pg_out_valid(pg_out_valid), .pg_out_ready(pg_out_ready), .pg_out_data(pg_out_data),
        .pg_out_upper(pg_out_upper), .pg_out_done(pg_out_done),
        .pg_in_valid(pg_in_valid), .pg_in_ready(pg_in_ready), .pg_in_data(pg_in_data),
        .rd_page_upper(rd_page_upper),
        .cw_out_valid(cw_out_valid), .cw_out_ready(cw_out_ready), .cw_out_data(cw_out_data)
    );

    function automatic logic [7:0] pat(input int pair, input int c, input int j);
        return 8'((pair * 37 + c * 11 + j * 3 + 1) & 8'hFF);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk);
        wr_in_valid = 1'b1;
        wr_in_data  = d;
        #1;
        while (!wr_in_ready) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic run_pair(input int pair);
        int got;
        int cyc;
        // Write side: C codewords (R3)
        for (int c = 0; c < SLOTS; c++)
            for (int j = 0; j < CW; j++)
                push(pat(pair, c, j));
        @(negedge clk);
        wr_in_valid = 1'b0;
        #1;
        chk(wr_in_ready == 1'b0, "R3 full pair blocks input", int'(wr_in_ready), 0);
        chk(pg_out_valid && !pg_out_upper, "R5 lower page first", int'(pg_out_upper), 0);
        // Drain both pages (R2 R4 R5 R6)
        got = 0;
        cyc = 0;
        while (got < 2 * PAGE) begin
            if (got != 0 || cyc != 0) @(negedge clk);
            pg_out_ready = (pair == 0) ? 1'b1 : (((cyc * 7 + pair) % 5) != 0);
            cyc++;
            #1;
            if (pg_out_valid && pg_out_ready) begin
                int o;
                int up;
                logic [7:0] exp;
                o  = got % PAGE;
                up = (got >= PAGE) ? 1 : 0;
                if (o < USED) exp = pat(pair, o / HALF, (o % HALF) + up * HALF);
                else exp = 8'hFF;
                if (o < USED) chk(pg_out_data == exp, "R2 half placement", int'(pg_out_data), int'(exp));
                else chk(pg_out_data == exp, "R4 tail pad", int'(pg_out_data), int'(exp));
                chk(int'(pg_out_upper) == up, "R5 page select", int'(pg_out_upper), up);
                chk(pg_out_done == (o == PAGE - 1), "R6 done strobe", int'(pg_out_done), int'(o == PAGE - 1));
                if (up == 1) hi_pg[o] = pg_out_data;
                else lo_pg[o] = pg_out_data;
                got++;
            end
        end
        @(negedge clk);
        pg_out_ready = 1'b0;
        #1;
        chk(wr_in_ready && !pg_out_valid, "R3 input reopens", int'(wr_in_ready), 1);
        // Read side: load lower then upper, with junk tails (R4 R7)
        for (int k = 0; k < 2 * PAGE; k++) begin
            int o;
            o = k % PAGE;
            @(negedge clk);
            pg_in_valid = 1'b1;
            if (o >= USED) pg_in_data = 8'(8'hA5 ^ k);
            else pg_in_data = (k >= PAGE) ? hi_pg[o] : lo_pg[o];
            #1;
            while (!pg_in_ready) begin
                @(negedge clk);
                #1;
            end
            chk(int'(rd_page_upper) == int'(k >= PAGE), "R7 page expected", int'(rd_page_upper), int'(k >= PAGE));
        end
        @(negedge clk);
        pg_in_valid = 1'b0;
        #1;
        chk(!pg_in_ready && cw_out_valid, "R7 emit blocks loading", int'(pg_in_ready), 0);
        // Rebuilt codeword order (R8)
        got = 0;
        cyc = 0;
        while (got < TOTAL) begin
            if (got != 0 || cyc != 0) @(negedge clk);
            cw_out_ready = (pair == 0) ? 1'b1 : (((cyc * 3 + pair) % 4) != 0);
            cyc++;
            #1;
            if (cw_out_valid && cw_out_ready) begin
                logic [7:0] exp;
                exp = pat(pair, got / CW, got % CW);
                chk(cw_out_data == exp, "R8 codeword order", int'(cw_out_data), int'(exp));
                got++;
            end
        end
        @(negedge clk);
        cw_out_ready = 1'b0;
        #1;
        chk(!cw_out_valid && pg_in_ready, "R8 exact byte count", int'(cw_out_valid), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(wr_in_ready && !pg_out_valid && pg_in_ready && !rd_page_upper && !cw_out_valid,
            "R1 reset state", int'({wr_in_ready, pg_out_valid, pg_in_ready, rd_page_upper, cw_out_valid}), 5'b10100);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(wr_in_ready && !pg_out_valid && pg_in_ready && !cw_out_valid,
            "R1 state after release", int'(wr_in_ready), 1);
        for (int p = 0; p < 3; p++) run_pair(p);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule